// File: doc/BRIEF.md
# Single-Wire Bus Slave with Identity Selection

This block is the device side of a single-wire, open-drain, time-slotted bus. A bus master starts every bit with a falling edge. The block decides from the length of each low whether it saw a bit slot or a bus reset. It answers a reset with a presence pulse. In each slot it either samples the master's bit or sends one of its own by holding the line low for a short time. All timing comes from a microsecond tick that a prescaler derives from the system clock.

Above the timing layer sits an identity layer. The 64-bit identity is an 8-bit family byte, a 48-bit serial number and an 8-bit check byte, and the check byte is computed in hardware from the other 56 bits. After each reset the master sends a command byte. That byte can read the identity, select one device by its full identity, select without addressing, or start a bitwise search in which all devices answer at once on the wired-AND line. A second form of the search brings in only devices with a pending interrupt.

Once selection succeeds, the block opens a session and passes byte traffic to an upper memory engine over two streams. The receive stream carries a one-byte holding register. The wire cannot be stalled, so a byte that the engine has not taken when the next one completes is replaced by the newer byte. The transmit stream is accepted only at a byte boundary between slots, and an accepted byte is sent in the next eight slots. The engine treats a fall of `session_o` as the end of its transaction.

Top module: `onewire_slave`

## Requirements
- R1: When the line rises after a low of at least RESET_US (480) µs, the block leaves the line released for about PD_WAIT_US (30) µs and then pulls it low for PD_LOW_US (120) µs.
- R2: While the block is taking part in a transaction (any state except dormant), a low longer than ABORT_US (120) µs also counts as a reset and draws a presence pulse. In the dormant state a 150 µs low draws none.
- R3: Each falling edge starts a slot, and the line is sampled SAMPLE_US (30) µs after the edge. A 0 is sent by holding the line low until HOLD_US (15) µs after the edge. A 1 is sent by leaving the line alone.
- R4: The command byte is taken least significant bit first. Its codes are: 33h read identity, 55h select by identity, CCh select without address, F0h search, ECh interrupt search. Any other code makes the block dormant, and it drives nothing until the next reset.
- R5: Read identity sends the 64 identity bits LSB first: family byte, then serial number, then check byte. A session then opens.
- R6: The check byte is the CRC of the 56 family and serial bits, taken LSB first, with polynomial x^8+x^5+x^4+1 and a start value of zero. Feeding all 64 bits through the same CRC gives zero.
- R7: Select by identity compares 64 bits received from the master. A full match opens a session. Any mismatching bit makes the block dormant.
- R8: For each identity bit, search sends the bit, then its complement, then reads the master's choice. A choice that differs from the bit makes the block dormant. After the 64th bit a session opens.
- R9: Interrupt search behaves like search if irq_pending is high when the command byte completes. Otherwise the block becomes dormant.
- R10: Select without address opens a session directly after the command byte.
- R11: In a session, slots with no loaded transmit byte are received as bits and packed LSB first into bytes. rx_valid stays high until rx_ready is seen. A byte that completes while rx_valid is high replaces the held byte.
- R12: tx_ready is high only in a session, at a byte boundary, with no slot in progress. An accepted byte is sent LSB first in the next eight slots.
- R13: session_o is high only while a session is open. Any reset event clears it.
- R14: After rst_n the line is released and session_o, rx_valid and tx_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw level of the bus line (synchronized inside) |
| line_pd_o | output | 1 | Open-drain pull-down enable, 1 pulls the line low |
| id_family | input | 8 | Family byte of the identity |
| id_serial | input | 48 | Serial number of the identity |
| irq_pending | input | 1 | An unacknowledged interrupt exists (gates interrupt search) |
| session_o | output | 1 | A session is open for the memory engine |
| rx_data | output | 8 | Byte received from the master |
| rx_valid | output | 1 | rx_data holds an untaken byte |
| rx_ready | input | 1 | Memory engine takes rx_data |
| tx_data | input | 8 | Byte to send to the master |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Block accepts tx_data this cycle |

## Verification
The line input passes through a two-stage synchronizer, an edge register and an output register. Every result on the line therefore appears about two microsecond ticks after the event that triggers it: a sent 0 begins about 2 µs after the master's falling edge and ends about 17 µs after it, and presence starts about 31 µs after release and ends about 151 µs after it. The bench reads the line only at fixed points well inside those windows: 10 and 22 µs into a read slot, and 15, 60 and 200 µs after a reset. A received byte reaches rx_valid about 31 µs after the falling edge of its eighth slot, and the bench looks at it only once that slot has ended. tx_ready and session_o are read on the falling clock edge once the command slot has finished.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [2:0] {
    LK_IDLE, LK_SLOT, LK_WAITHI, LK_PWAIT, LK_PLOW
  } link_st_t;

  typedef enum logic [2:0] {
    SEL_DORMANT, SEL_CMD, SEL_READ, SEL_MATCH, SEL_SEARCH, SEL_SESSION
  } sel_st_t;

  localparam logic [7:0] OP_READ_ID   = 8'h33;
  localparam logic [7:0] OP_SELECT_ID = 8'h55;
  localparam logic [7:0] OP_ANY       = 8'hCC;
  localparam logic [7:0] OP_SEARCH    = 8'hF0;
  localparam logic [7:0] OP_IRQ_SRCH  = 8'hEC;
endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end
  assign q = sr[STAGES-1];
endmodule

// File: rtl/ow_crc8.sv
module ow_crc8 #(
  parameter int DATA_BITS = 56
) (
  input  logic [DATA_BITS-1:0] data,
  output logic [7:0]           crc
);
  // reflected form of x^8+x^5+x^4+1, bit 0 enters first
  always_comb begin
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 0; i < DATA_BITS; i++) begin
      fb = c[0] ^ data[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    crc = c;
  end
endmodule

// File: rtl/ow_link.sv
module ow_link
  import ow_pkg::*;
#(
  parameter int CLKS_PER_US = 250,
  parameter int RESET_US    = 480,
  parameter int ABORT_US    = 120,
  parameter int PD_WAIT_US  = 30,
  parameter int PD_LOW_US   = 120,
  parameter int SAMPLE_US   = 30,
  parameter int HOLD_US     = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  input  logic abort_en,
  input  logic tx_en,
  input  logic tx_bit,
  output logic pd_o,
  output logic bus_reset,
  output logic bit_done,
  output logic bit_val,
  output logic slot_busy
);
  localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam int CW = $clog2(RESET_US + PD_LOW_US + PD_WAIT_US + SAMPLE_US + 2);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  link_st_t        st;
  logic [PW-1:0]   pre;
  logic            tick;
  logic [CW-1:0]   cnt, cnt_inc, low_us;
  logic            line_q, fall, rise, in_pd, is_rst, drv, pd_n;

  assign tick    = (pre == PW'(CLKS_PER_US - 1));
  assign cnt_inc = cnt + CW'(1);
  assign fall    = line_q & ~line_s;
  assign rise    = ~line_q & line_s;
  assign in_pd   = (st == LK_PWAIT) || (st == LK_PLOW);
  assign is_rst  = rise && !in_pd &&
                   ((low_us >= CW'(RESET_US)) || (abort_en && low_us > CW'(ABORT_US)));
  assign pd_n    = (st == LK_PLOW) || (st == LK_SLOT && drv && cnt < CW'(HOLD_US));
  assign slot_busy = (st != LK_IDLE) || fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre    <= '0;
      line_q <= 1'b1;
      low_us <= '0;
    end else begin
      pre    <= tick ? '0 : pre + PW'(1);
      line_q <= line_s;
      if (in_pd || fall)                           low_us <= '0;
      else if (tick && !line_s && low_us != CMAX)  low_us <= low_us + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LK_IDLE;
      cnt       <= '0;
      drv       <= 1'b0;
      pd_o      <= 1'b0;
      bus_reset <= 1'b0;
      bit_done  <= 1'b0;
      bit_val   <= 1'b1;
    end else begin
      bus_reset <= 1'b0;
      bit_done  <= 1'b0;
      pd_o      <= pd_n;
      if (is_rst) begin
        st        <= LK_PWAIT;
        cnt       <= '0;
        drv       <= 1'b0;
        bus_reset <= 1'b1;
      end else begin
        case (st)
          LK_IDLE: if (fall) begin
            st  <= LK_SLOT;
            cnt <= '0;
            drv <= tx_en & ~tx_bit;
          end
          LK_SLOT: if (tick) begin
            cnt <= cnt_inc;
            if (cnt_inc == CW'(SAMPLE_US)) begin
              bit_done <= 1'b1;
              bit_val  <= line_s;
              st       <= LK_WAITHI;
            end
          end
          LK_WAITHI: if (line_s) st <= LK_IDLE;
          LK_PWAIT: if (tick) begin
            cnt <= cnt_inc;
            if (cnt_inc == CW'(PD_WAIT_US)) begin
              st  <= LK_PLOW;
              cnt <= '0;
            end
          end
          LK_PLOW: if (tick) begin
            cnt <= cnt_inc;
            if (cnt_inc == CW'(PD_LOW_US)) st <= LK_IDLE;
          end
          default: st <= LK_IDLE;
        endcase
      end
    end
  end

  // R3: the pull-down for a sent 0 never outlasts the hold window
  a_r3_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_SLOT && cnt > CW'(HOLD_US)) |-> !pd_o);
  // R1: the line stays released during the wait before presence
  a_r1_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_PWAIT && $past(st) == LK_PWAIT) |-> !pd_o);
endmodule

// File: rtl/ow_select.sv
module ow_select
  import ow_pkg::*;
#(
  parameter int ID_BITS   = 64,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_reset,
  input  logic                 bit_done,
  input  logic                 bit_val,
  input  logic                 slot_busy,
  input  logic [ID_BITS-1:0]   id,
  input  logic                 irq_pending,
  output logic                 tx_en,
  output logic                 tx_bit,
  output logic                 abort_en,
  output logic                 session,
  output logic [BYTE_BITS-1:0] rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  input  logic [BYTE_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready
);
  localparam int IW = $clog2(ID_BITS);
  localparam int BW = $clog2(BYTE_BITS);
  localparam logic [IW-1:0] ILAST = IW'(ID_BITS - 1);
  localparam logic [BW-1:0] BLAST = BW'(BYTE_BITS - 1);

  sel_st_t              st;
  logic [IW-1:0]        idx;
  logic [1:0]           ph;
  logic [BW-1:0]        bcnt;
  logic [BYTE_BITS-1:0] sh, sh_next, txsh;
  logic                 txm, last_bit, own_bit;

  assign sh_next  = {bit_val, sh[BYTE_BITS-1:1]};
  assign last_bit = (idx == ILAST);
  assign own_bit  = id[idx];
  assign abort_en = (st != SEL_DORMANT);
  assign session  = (st == SEL_SESSION);
  assign tx_ready = session && !txm && (bcnt == '0) && !slot_busy;

  always_comb begin
    tx_en  = 1'b0;
    tx_bit = 1'b1;
    case (st)
      SEL_READ: begin
        tx_en  = 1'b1;
        tx_bit = own_bit;
      end
      SEL_SEARCH: begin
        tx_en  = (ph != 2'd2);
        tx_bit = (ph == 2'd0) ? own_bit : ~own_bit;
      end
      SEL_SESSION: begin
        tx_en  = txm;
        tx_bit = txsh[0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SEL_DORMANT;
      idx      <= '0;
      ph       <= 2'd0;
      bcnt     <= '0;
      sh       <= '0;
      txsh     <= '0;
      txm      <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (bus_reset) begin
      st       <= SEL_CMD;
      idx      <= '0;
      ph       <= 2'd0;
      bcnt     <= '0;
      txm      <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (tx_valid && tx_ready) begin
        txm  <= 1'b1;
        txsh <= tx_data;
      end
      if (bit_done) begin
        case (st)
          SEL_CMD: begin
            sh   <= sh_next;
            bcnt <= bcnt + BW'(1);
            if (bcnt == BLAST) begin
              bcnt <= '0;
              idx  <= '0;
              ph   <= 2'd0;
              case (sh_next)
                OP_READ_ID:   st <= SEL_READ;
                OP_SELECT_ID: st <= SEL_MATCH;
                OP_ANY:       st <= SEL_SESSION;
                OP_SEARCH:    st <= SEL_SEARCH;
                OP_IRQ_SRCH:  st <= irq_pending ? SEL_SEARCH : SEL_DORMANT;
                default:      st <= SEL_DORMANT;
              endcase
            end
          end
          SEL_READ: begin
            idx <= idx + IW'(1);
            if (last_bit) st <= SEL_SESSION;
          end
          SEL_MATCH: begin
            idx <= idx + IW'(1);
            if (bit_val != own_bit) st <= SEL_DORMANT;
            else if (last_bit)      st <= SEL_SESSION;
          end
          SEL_SEARCH: begin
            if (ph == 2'd2) begin
              ph <= 2'd0;
              if (bit_val != own_bit) st <= SEL_DORMANT;
              else begin
                idx <= idx + IW'(1);
                if (last_bit) st <= SEL_SESSION;
              end
            end else begin
              ph <= ph + 2'd1;
            end
          end
          SEL_SESSION: begin
            bcnt <= bcnt + BW'(1);
            if (txm) begin
              txsh <= txsh >> 1;
              if (bcnt == BLAST) begin
                txm  <= 1'b0;
                bcnt <= '0;
              end
            end else begin
              sh <= sh_next;
              if (bcnt == BLAST) begin
                rx_data  <= sh_next;
                rx_valid <= 1'b1;
                bcnt     <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R13: any reset event closes the session
  a_r13_reset_closes: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !session);
  // R11: an untaken byte stays offered
  a_r11_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !bus_reset) |=> rx_valid);
  // R12: an accepted byte starts sending from its first bit
  a_r12_tx_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (txm && bcnt == '0));
  // R7: a matching bit advances the compare by one position
  a_r7_match_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEL_MATCH && bit_done && !bus_reset && bit_val == own_bit && !last_bit)
      |=> (st == SEL_MATCH && idx == $past(idx) + IW'(1)));
endmodule

// File: rtl/onewire_slave.sv
module onewire_slave #(
  parameter int CLKS_PER_US = 250,
  parameter int SYNC_STAGES = 2,
  parameter int RESET_US    = 480,
  parameter int ABORT_US    = 120,
  parameter int PD_WAIT_US  = 30,
  parameter int PD_LOW_US   = 120,
  parameter int SAMPLE_US   = 30,
  parameter int HOLD_US     = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_i,
  output logic        line_pd_o,
  input  logic [7:0]  id_family,
  input  logic [47:0] id_serial,
  input  logic        irq_pending,
  output logic        session_o,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  output logic        tx_ready
);
  localparam int BODY_BITS = 56;

  logic        line_s, abort_en, tx_en, tx_bit;
  logic        bus_reset, bit_done, bit_val, slot_busy;
  logic [7:0]  crc;
  logic [63:0] id;

  ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_i), .q(line_s)
  );

  ow_crc8 #(.DATA_BITS(BODY_BITS)) u_crc (
    .data({id_serial, id_family}), .crc(crc)
  );
  assign id = {crc, id_serial, id_family};

  ow_link #(
    .CLKS_PER_US(CLKS_PER_US), .RESET_US(RESET_US), .ABORT_US(ABORT_US),
    .PD_WAIT_US(PD_WAIT_US), .PD_LOW_US(PD_LOW_US),
    .SAMPLE_US(SAMPLE_US), .HOLD_US(HOLD_US)
  ) u_link (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .abort_en(abort_en),
    .tx_en(tx_en), .tx_bit(tx_bit), .pd_o(line_pd_o), .bus_reset(bus_reset),
    .bit_done(bit_done), .bit_val(bit_val), .slot_busy(slot_busy)
  );

  ow_select #(.ID_BITS(64), .BYTE_BITS(8)) u_sel (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .bit_done(bit_done),
    .bit_val(bit_val), .slot_busy(slot_busy), .id(id), .irq_pending(irq_pending),
    .tx_en(tx_en), .tx_bit(tx_bit), .abort_en(abort_en), .session(session_o),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );
endmodule

// File: tb/tb_onewire_slave.sv
module tb_onewire_slave;
  localparam int CPU = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_low = 1'b0;
  logic        line, line_pd;
  logic [7:0]  fam = 8'h3C;
  logic [47:0] ser = '0;
  logic        irq = 1'b0;
  logic        sess, rxv, rxr = 1'b0, txv = 1'b0, txr;
  logic [7:0]  rxd, txd = '0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;
  assign line = ~m_low & ~line_pd;

  onewire_slave #(.CLKS_PER_US(CPU)) dut (
    .clk(clk), .rst_n(rst_n), .line_i(line), .line_pd_o(line_pd),
    .id_family(fam), .id_serial(ser), .irq_pending(irq), .session_o(sess),
    .rx_data(rxd), .rx_valid(rxv), .rx_ready(rxr),
    .tx_data(txd), .tx_valid(txv), .tx_ready(txr)
  );

  function automatic logic [7:0] crc_of(input logic [63:0] d, input int n);
    logic [7:0] c = 8'h00;
    logic fb;
    for (int i = 0; i < n; i++) begin
      fb = d[i] ^ c[0];
      c  = {fb, c[7:1]} ^ (fb ? 8'h0C : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [63:0] exp_id();
    return {crc_of({8'h00, ser, fam}, 56), ser, fam};
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic us(input int n);
    repeat (n * CPU) @(negedge clk);
  endtask

  task automatic pulse(input int low, output logic s15, output logic s60, output logic s200);
    m_low = 1'b1; us(low); m_low = 1'b0;
    us(15);  s15 = line;
    us(45);  s60 = line;
    us(140); s200 = line;
    us(50);
  endtask

  task automatic wbit(input logic b);
    m_low = 1'b1;
    if (b) begin us(3); m_low = 1'b0; us(67); end
    else   begin us(65); m_low = 1'b0; us(5); end
  endtask

  task automatic rbit2(output logic b10, output logic b22);
    m_low = 1'b1; us(3); m_low = 1'b0;
    us(7);  b10 = line;
    us(12); b22 = line;
    us(48);
  endtask

  task automatic rbit(output logic b);
    logic x;
    rbit2(b, x);
  endtask

  task automatic wbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wbit(v[i]);
  endtask

  task automatic rbyte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) rbit(v[i]);
  endtask

  task automatic do_reset(input string req);
    logic a, b, c;
    pulse(500, a, b, c);
    chk(req, "presence shape", {a, b, c}, 3'b101);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] got, id;
    logic [7:0]  v, b8;
    logic        a, b, c, h10, h22;
    int          miss, k;
    void'($urandom(32'd7413));
    ser = {$urandom(), $urandom()};
    id  = exp_id();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R14 reset state
    chk("R14", "line released", line, 1'b1);
    chk("R14", "session", sess, 1'b0);
    chk("R14", "rx_valid", rxv, 1'b0);
    chk("R14", "tx_ready", txr, 1'b0);

    // R1 presence after a long low
    do_reset("R1");

    // R4 command LSB first, R5 read identity, R6 check byte
    wbyte(8'h33);
    for (int i = 0; i < 64; i++) rbit(got[i]);
    chk("R5", "identity bits", got, id);
    chk("R6", "check byte", got[63:56], crc_of(got, 56));
    chk("R6", "remainder over 64 bits", crc_of(got, 64), 8'h00);
    chk("R13", "session after read", sess, 1'b1);

    // R2 abort low in session
    pulse(150, a, b, c);
    chk("R2", "presence after 150us in session", {a, b, c}, 3'b101);
    chk("R13", "session cleared by reset", sess, 1'b0);

    // R7 select by full identity, then R11 receive
    wbyte(8'h55);
    for (int i = 0; i < 64; i++) wbit(id[i]);
    chk("R7", "session after match", sess, 1'b1);
    v = 8'($urandom());
    wbyte(v);
    chk("R11", "rx_valid after byte", rxv, 1'b1);
    chk("R11", "rx_data", rxd, v);
    b8 = 8'($urandom());
    wbyte(b8);
    chk("R11", "newer byte replaces held", rxd, b8);
    chk("R11", "still valid", rxv, 1'b1);
    rxr = 1'b1; @(negedge clk); rxr = 1'b0; @(negedge clk);
    chk("R11", "rx_valid after take", rxv, 1'b0);

    // R10 select without address, R12 transmit, R3 hold window
    do_reset("R1");
    wbyte(8'hCC);
    chk("R10", "session after skip", sess, 1'b1);
    chk("R12", "tx_ready at boundary", txr, 1'b1);
    v = 8'($urandom()) & 8'hFE;
    txd = v; txv = 1'b1; @(negedge clk); txv = 1'b0;
    chk("R12", "tx_ready drops after accept", txr, 1'b0);
    rbit2(h10, h22);
    chk("R3", "sent 0 low at 10us / released at 22us", {h10, h22}, 2'b01);
    got[0] = h10;
    for (int i = 1; i < 8; i++) rbit(got[i]);
    chk("R12", "sent byte", got[7:0], v);
    chk("R12", "tx_ready back after byte", txr, 1'b1);

    // R7 mismatch makes dormant
    do_reset("R1");
    k = $urandom_range(63, 0);
    wbyte(8'h55);
    for (int i = 0; i < 64; i++) wbit(i == k ? ~id[i] : id[i]);
    chk("R7", "no session on mismatch", sess, 1'b0);
    rbyte(v);
    chk("R7", "dormant drives nothing", v, 8'hFF);

    // R8 full search
    do_reset("R1");
    wbyte(8'hF0);
    miss = 0;
    for (int i = 0; i < 64; i++) begin
      rbit(a); rbit(b);
      if (a !== id[i] || b !== ~id[i]) miss++;
      wbit(id[i]);
    end
    chk("R8", "bit/complement errors", miss, 0);
    chk("R8", "session after search", sess, 1'b1);

    // R8 drop out on a differing choice
    do_reset("R1");
    k = $urandom_range(12, 0);
    wbyte(8'hF0);
    for (int i = 0; i < k; i++) begin rbit(a); rbit(b); wbit(id[i]); end
    rbit(a); rbit(b); wbit(~id[k]);
    rbit(a); rbit(b);
    chk("R8", "silent after drop", {a, b}, 2'b11);
    chk("R8", "no session after drop", sess, 1'b0);

    // R9 interrupt search without pending interrupt
    do_reset("R1");
    irq = 1'b0;
    wbyte(8'hEC);
    rbit(a); rbit(b);
    chk("R9", "no answer without irq", {a, b}, 2'b11);

    // R9 interrupt search with pending interrupt
    do_reset("R1");
    irq = 1'b1;
    wbyte(8'hEC);
    miss = 0;
    for (int i = 0; i < 8; i++) begin
      rbit(a); rbit(b);
      if (a !== id[i] || b !== ~id[i]) miss++;
      wbit(id[i]);
    end
    chk("R9", "answers with irq", miss, 0);
    irq = 1'b0;

    // R4 unknown code, R2 dormant ignores a short abort low
    do_reset("R1");
    wbyte(8'h96);
    rbyte(v);
    chk("R4", "unknown code silent", v, 8'hFF);
    chk("R4", "no session", sess, 1'b0);
    pulse(150, a, b, c);
    chk("R2", "no presence when dormant", b, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule